// File: doc/BRIEF.md
# Factorial Compute Register Unit

A small memory-mapped register block that holds an iterative factorial engine. Software sees four 32-bit registers on a simple single-cycle read/write bus: a fixed identification word, a scratch register that returns the complement of what was last written to it, a combined operand/result register, and a status register. A read returns its data combinationally in the same cycle as the request. A write is applied at the clock edge on which it is presented.

Writing an operand while the engine is idle starts a computation. The engine multiplies a 32-bit accumulator by a down-counter once per clock until the counter reaches zero. It then writes the wrapped product back into the operand register and clears the busy flag. If the interrupt enable in the status register is set at that point, the block pulses a request line toward an external interrupt status block.

Top module: `fact_regs`

## Requirements
- R1: A 4-byte read at offset 0x00 returns the constant 0x010000ED.
- R2: A 4-byte read at offset 0x04 returns the bitwise complement of the last value written there with a 4-byte write.
- R3: For offsets below 0x80, an access whose `bus_size` (byte count) is not 4 has no effect on any register, and a read of that kind returns 0xFFFFFFFF.
- R4: The mapped offsets are 0x00, 0x04, 0x08 and 0x20. A read of any other offset, including every offset from 0x80 upward, returns 0xFFFFFFFF.
- R5: A 4-byte write to 0x08 while the busy flag (status bit 0) is clear stores the operand and sets busy. While busy is set, such writes are dropped and the register holds its value.
- R6: The result is n·(n-1)·…·1 modulo 2^32, computed from an accumulator that starts at 1. An operand of 0 therefore yields 1.
- R7: Busy stays set for n+1 clock edges after the edge that accepted operand n. On the edge where busy clears, the result replaces the operand at 0x08.
- R8: Status bit 7 is a read/write interrupt enable. A write to status bit 0 has no effect, and all other status bits read 0.
- R9: `fact_irq` is high for exactly one cycle, starting at the edge on which busy clears, and only if the enable bit is set at that edge.
- R10: A synchronous active-high reset clears the operand, the stored scratch value (0x04 then reads 0), busy and the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| fact_irq | output | 1 | One-cycle completion interrupt request |

## Verification
A corrupted down-counter or accumulator shows up at offset 0x08 once busy drops, as a wrong product. The bench compares that product against its own wrapped model and counts the busy cycles polled, so an off-by-one in the loop appears within n+2 cycles of the operand write. A wrong busy or enable state is seen on the next status read. It also shows as a missing or extra `fact_irq` pulse in the cycle busy falls, or as an operand overwritten during a computation.

// File: rtl/fact_regs.sv
module fact_regs #(
  parameter int ADDR_W = 8,
  parameter logic [31:0] ID_WORD = 32'h010000ED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              fact_irq
);
  localparam logic [ADDR_W-1:0] OFS_ID   = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_SCR  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_OPND = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] LOW_TOP  = ADDR_W'('h80);
  localparam int IEN_BIT = 7;

  logic [31:0] scr_inv, opnd, acc, cnt;
  logic        busy, ien;

  wire size_ok = (bus_addr >= LOW_TOP) || (bus_size == 4'd4);
  wire wr_ok   = bus_sel && bus_we && size_ok;
  wire done    = busy && (cnt == 32'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      scr_inv  <= '0;
      opnd     <= '0;
      acc      <= 32'd1;
      cnt      <= '0;
      busy     <= 1'b0;
      ien      <= 1'b0;
      fact_irq <= 1'b0;
    end else begin
      fact_irq <= done && ien;
      if (busy) begin
        if (done) begin
          opnd <= acc;
          busy <= 1'b0;
        end else begin
          acc <= acc * cnt;
          cnt <= cnt - 32'd1;
        end
      end
      if (wr_ok) begin
        unique case (bus_addr)
          OFS_SCR:  scr_inv <= ~bus_wdata;
          OFS_OPND: if (!busy) begin
                      opnd <= bus_wdata;
                      cnt  <= bus_wdata;
                      acc  <= 32'd1;
                      busy <= 1'b1;
                    end
          OFS_STAT: ien <= bus_wdata[IEN_BIT];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '1;
    if (bus_sel && !bus_we && size_ok) begin
      unique case (bus_addr)
        OFS_ID:   bus_rdata = ID_WORD;
        OFS_SCR:  bus_rdata = scr_inv;
        OFS_OPND: bus_rdata = opnd;
        OFS_STAT: bus_rdata = {24'd0, ien, 6'd0, busy};
        default:  bus_rdata = '1;
      endcase
    end
  end

  AST_OPND_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != 32'd0) |=> $stable(opnd)); // R5
  AST_ACC_SEED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> acc == 32'd1); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != 32'd0) |=> (cnt == $past(cnt) - 32'd1) && busy); // R7
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
    fact_irq |-> (!busy && $past(busy))); // R9
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    fact_irq |-> $past(ien)); // R9
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    fact_irq |=> !fact_irq); // R9
endmodule

// File: tb/fact_regs_tb_top.sv
module fact_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_size = 4'd4;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fact_irq;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fact_regs dut_i (.clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .fact_irq(fact_irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] sz = 4'd4);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_size = 4'd4;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] sz = 4'd4);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
    #1 d = bus_rdata;
    bus_sel = 1'b0; bus_size = 4'd4;
  endtask

  function automatic logic [31:0] model_fact(input int n);
    logic [31:0] r = 32'd1;
    for (int i = n; i > 0; i--) r = r * 32'(i);
    return r;
  endfunction

  // Write operand, poll status each cycle, count busy cycles and irq pulses.
  task automatic run_fact(input int n, input bit en, input string tag);
    logic [31:0] d;
    int busy_cycles = 0, irq_seen = 0, irq_at_end = 0;
    wr(8'h08, 32'(n));
    forever begin
      rd(8'h20, d);
      if (fact_irq) irq_seen++;
      if (d[0] == 1'b0) begin irq_at_end = fact_irq; break; end
      busy_cycles++;
      if (busy_cycles > 200) break;
      @(negedge clk);
    end
    check({tag, " R7 latency"}, busy_cycles, n + 1);
    rd(8'h08, d);
    check({tag, " R6 result"}, d, model_fact(n));
    check({tag, " R9 irq at end"}, irq_at_end, {31'd0, en});
    @(negedge clk);
    if (fact_irq) irq_seen++;
    check({tag, " R9 single pulse"}, irq_seen, en ? 1 : 0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    rd(8'h00, d); check("R1 id", d, 32'h010000ED);
    rd(8'h04, d); check("R10 scratch reset", d, 32'h0);
    rd(8'h08, d); check("R10 operand reset", d, 32'h0);
    rd(8'h20, d); check("R10 status reset", d, 32'h0);
    check("R10 irq low", fact_irq, 1'b0);
  endtask

  task automatic t_scratch;
    logic [31:0] d;
    wr(8'h04, 32'h1234_5678);
    rd(8'h04, d); check("R2 inverse", d, 32'hEDCB_A987);
    wr(8'h04, 32'hFFFF_0000);
    rd(8'h04, d); check("R2 inverse 2", d, 32'h0000_FFFF);
  endtask

  task automatic t_size;
    logic [31:0] d;
    rd(8'h00, d, 4'd2); check("R3 short read id", d, 32'hFFFF_FFFF);
    rd(8'h04, d, 4'd8); check("R3 wide read scratch", d, 32'hFFFF_FFFF);
    wr(8'h04, 32'hAAAA_AAAA, 4'd2);
    rd(8'h04, d); check("R3 short write dropped", d, 32'h0000_FFFF);
    wr(8'h08, 32'd3, 4'd1);
    rd(8'h20, d); check("R3 short operand write no start", d, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(8'h0C, d); check("R4 unmapped 0x0C", d, 32'hFFFF_FFFF);
    rd(8'h24, d); check("R4 unmapped 0x24", d, 32'hFFFF_FFFF);
    rd(8'h80, d); check("R4 unmapped 0x80", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_status;
    logic [31:0] d;
    wr(8'h20, 32'h0000_0081);
    rd(8'h20, d); check("R8 enable set, busy untouched", d, 32'h80);
    rd(8'h08, d); check("R8 no start from status write", d, 32'h0);
    wr(8'h20, 32'h0000_0001);
    rd(8'h20, d); check("R8 enable clear", d, 32'h0);
  endtask

  task automatic t_busy_drop;
    logic [31:0] d;
    wr(8'h08, 32'd10);
    rd(8'h20, d); check("R5 busy set", d, 32'h1);
    rd(8'h08, d); check("R5 operand stored", d, 32'd10);
    wr(8'h08, 32'd2);
    rd(8'h08, d); check("R5 write during busy dropped", d, 32'd10);
    repeat (14) @(negedge clk);
    rd(8'h08, d); check("R5 result from first operand", d, model_fact(10));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_scratch();
    t_size();
    t_unmapped();
    t_status();
    run_fact(0, 1'b0, "n0");
    run_fact(5, 1'b0, "n5 noirq");
    wr(8'h20, 32'h80);
    run_fact(5, 1'b1, "n5 irq");
    run_fact(13, 1'b1, "n13 wrap");
    run_fact(20, 1'b1, "n20 wrap");
    wr(8'h20, 32'h0);
    t_busy_drop();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule